// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block lets a clocked host read and write an external asynchronous static RAM of up to 2^20 words of 16 bits, with each byte lane selected on its own. The host hands over one request at a time through a ready/valid handshake. A request carries a direction flag, a word address, write data and a per-lane enable. The controller answers with a one-cycle done pulse, and after a read it also returns registered read data.

On the memory side every pin is driven straight from a flop. The pins are: the address, an active-low select, an active-high select, an active-low output enable, an active-low write enable and one active-low strobe per byte lane. The data bus is split into an outgoing word with its own driver enable and an incoming word.

Read and write windows are built from parameterised clock counts. Each count is the ceiling of a nanosecond limit divided by the clock period. During a write the output enable stays high, the driver is released on the same edge that raises the write enable, and the selects and strobes are held one cycle longer so that address and data hold past the end of the write.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the memory pins rest at the idle state until a request arrives: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_bs_n`=2'b11 and `mem_dout_en`=0. In that state `host_ready`=1 and `host_done`=0.
- R2: A read with a non-zero lane enable keeps both selects active, `mem_we_n` high and `mem_oe_n` low for RD_CYC = max(ceil(T_AA/CLK), ceil(T_RC/CLK)) cycles. `host_done` is high RD_CYC+1 cycles after the accepting edge.
- R3: Read data is captured in the last read cycle. Lane 0 is bits 7:0 and is enabled by `host_be[0]`; lane 1 is bits 15:8 and is enabled by `host_be[1]`. A lane that is not enabled reads back as zero.
- R4: A write with a non-zero lane enable holds `mem_we_n` low for WE_CYC = max(ceil(T_PWE), ceil(T_SD), ceil(T_SCS)) cycles, with `mem_oe_n` high and `mem_bs_n` equal to the inverse of the enable. The selects and strobes are then held for WR_CYC-WE_CYC further cycles, where WR_CYC = max(WE_CYC+1, ceil(T_WC)). Done follows WR_CYC+1 cycles after the accepting edge.
- R5: A write changes only the lanes it enables. The other lane of that word keeps its earlier content.
- R6: `mem_dout_en` is high only in cycles where `mem_we_n` is low and `mem_oe_n` was high in that cycle and the one before. It drops on the edge where `mem_we_n` rises.
- R7: A request whose lane enable is 2'b00 gives `host_done` on the next cycle and starts no memory cycle, so `mem_cs1_n` stays high. When such a request is a read, it returns zero.
- R8: `host_ready` is low from the accepting edge until the cycle in which done is shown. A new request may be accepted in the same cycle as that done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Request accepted on this edge when valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_be | input | DATA_W/8 | Lane enables, bit 0 = low byte |
| host_wdata | input | DATA_W | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs1_n | output | 1 | Active-low select |
| mem_cs2 | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bs_n | output | DATA_W/8 | Active-low lane strobes |
| mem_dout | output | DATA_W | Data driven toward memory |
| mem_dout_en | output | 1 | Driver enable for mem_dout |
| mem_din | input | DATA_W | Data returned by memory |

## Verification
Two events can fall in the same cycle: the done of one access and the acceptance of the next one. The case that matters most is a read that starts right after a write has released its driver. The bench provokes this by presenting each new request in the very cycle where done is observed, so writes, reads and zero-enable requests run back to back across a full sweep of lane enables and edge addresses. The outcome is judged by a bus model that flags any cycle where the driver is on while output enable is low, or where output enable was low one cycle before. The same model only commits bytes that were actually driven, and read-back data is compared with a shadow copy kept in the bench.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_READ   = 2'd1,
    PH_WPULSE = 2'd2,
    PH_WHOLD  = 2'd3
  } phase_e;

  function automatic int cyc_of(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
module asram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2,
  parameter int RD_CYC   = 3,
  parameter int WE_CYC   = 2,
  parameter int HOLD_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [LANES-1:0]  host_be,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output phase_e            phase_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [LANES-1:0]  be_d,
  output logic [DATA_W-1:0] wdata_d,
  output logic              capture,
  output logic              zero_rd
);
  localparam int MAX_CNT = max2(max2(RD_CYC, WE_CYC), HOLD_CYC);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_d;
  logic              accept;

  assign host_ready = (phase_q == PH_IDLE);
  assign accept     = host_ready && host_valid;
  assign capture    = (phase_q == PH_READ) && (cnt_q == '0);
  assign zero_rd    = accept && (host_be == '0) && !host_we;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    be_d    = be_q;
    wdata_d = wdata_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (host_valid) begin
          addr_d  = host_addr;
          be_d    = host_be;
          wdata_d = host_wdata;
          if (host_be == '0) begin
            done_d = 1'b1;
          end else if (host_we) begin
            phase_d = PH_WPULSE;
            cnt_d   = CNT_W'(WE_CYC - 1);
          end else begin
            phase_d = PH_READ;
            cnt_d   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      PH_READ: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WPULSE: begin
        if (cnt_q == '0) begin
          phase_d = PH_WHOLD;
          cnt_d   = CNT_W'(HOLD_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      host_done <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      host_done <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_d;
      be_q    <= be_d;
      wdata_q <= wdata_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAX_CNT) else $error("counter out of range"); // R4
  AST_WHOLD_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WHOLD && cnt_q == '0) |=> host_done) else $error("write end without done"); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_be != '0) |=> !host_ready) else $error("ready during access"); // R8
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [LANES-1:0]  be_d,
  input  logic [DATA_W-1:0] wdata_d,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en
);
  logic active_d;
  logic pulse_d;

  assign active_d = (phase_d != PH_IDLE);
  assign pulse_d  = (phase_d == PH_WPULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs1_n   <= 1'b1;
      mem_cs2     <= 1'b0;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_bs_n    <= '1;
      mem_dout_en <= 1'b0;
    end else begin
      mem_cs1_n   <= !active_d;
      mem_cs2     <= active_d;
      mem_oe_n    <= (phase_d != PH_READ);
      mem_we_n    <= !pulse_d;
      mem_bs_n    <= active_d ? ~be_d : '1;
      mem_dout_en <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (active_d) begin
      mem_addr <= addr_d;
      mem_dout <= wdata_d;
    end
  end

  AST_DRV_AFTER_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (mem_oe_n && $past(mem_oe_n))) else $error("driver with output enable"); // R6
  AST_WE_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dout_en) else $error("driver kept after write end"); // R6
  AST_WE_END_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs1_n && mem_cs2 && $stable(mem_bs_n) && $stable(mem_addr)))
    else $error("select dropped at write end"); // R4
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              zero_rd,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[l*8 +: 8] <= '0;
      end else if (capture || zero_rd) begin
        rdata[l*8 +: 8] <= (capture && be[l]) ? din[l*8 +: 8] : 8'h00;
      end
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 10000,
  parameter int T_RC_PS  = 25000,
  parameter int T_AA_PS  = 25000,
  parameter int T_WC_PS  = 25000,
  parameter int T_PWE_PS = 18000,
  parameter int T_SCS_PS = 18000,
  parameter int T_SD_PS  = 12000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_valid,
  output logic                  host_ready,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DATA_W/8-1:0]   host_be,
  input  logic [DATA_W-1:0]     host_wdata,
  output logic                  host_done,
  output logic [DATA_W-1:0]     host_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs1_n,
  output logic                  mem_cs2,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_bs_n,
  output logic [DATA_W-1:0]     mem_dout,
  output logic                  mem_dout_en,
  input  logic [DATA_W-1:0]     mem_din
);
  localparam int LANES    = DATA_W / 8;
  localparam int RD_CYC   = max2(max2(cyc_of(T_AA_PS, CLK_PS), cyc_of(T_RC_PS, CLK_PS)), 1);
  localparam int WE_CYC   = max2(max2(max2(cyc_of(T_PWE_PS, CLK_PS), cyc_of(T_SD_PS, CLK_PS)),
                                      cyc_of(T_SCS_PS, CLK_PS)), 1);
  localparam int WR_CYC   = max2(WE_CYC + 1, cyc_of(T_WC_PS, CLK_PS));
  localparam int HOLD_CYC = WR_CYC - WE_CYC;
  localparam int CNT_W    = $clog2(max2(RD_CYC, WR_CYC) + 1);

  logic              rst_sn;
  phase_e            phase_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  be_d;
  logic [DATA_W-1:0] wdata_d;
  logic              capture;
  logic              zero_rd;

  asram_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  asram_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LANES    (LANES),
    .RD_CYC   (RD_CYC),
    .WE_CYC   (WE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .CNT_W    (CNT_W)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .host_valid (host_valid),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_be    (host_be),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .host_done  (host_done),
    .phase_d    (phase_d),
    .addr_d     (addr_d),
    .be_d       (be_d),
    .wdata_d    (wdata_d),
    .capture    (capture),
    .zero_rd    (zero_rd)
  );

  asram_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) i_pins (
    .clk         (clk),
    .rst_n       (rst_sn),
    .phase_d     (phase_d),
    .addr_d      (addr_d),
    .be_d        (be_d),
    .wdata_d     (wdata_d),
    .mem_addr    (mem_addr),
    .mem_cs1_n   (mem_cs1_n),
    .mem_cs2     (mem_cs2),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_bs_n    (mem_bs_n),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
  );

  asram_lanes #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) i_lanes (
    .clk     (clk),
    .rst_n   (rst_sn),
    .capture (capture),
    .zero_rd (zero_rd),
    .be      (be_d),
    .din     (mem_din),
    .rdata   (host_rdata)
  );

  AST_CAPTURE_WHILE_OE: assert property (@(posedge clk) disable iff (!rst_sn)
    capture |-> (!mem_oe_n && mem_we_n && !mem_cs1_n)) else $error("capture outside read"); // R3
  AST_ZERO_BE_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_valid && host_ready && host_be == '0) |=> (mem_cs1_n && host_done)) else $error("empty request ran"); // R7
endmodule

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
  localparam int CLK_PS = 8000;
  localparam int E_RD   = (25000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WE0  = (18000 + CLK_PS - 1) / CLK_PS;
  localparam int E_SD   = (12000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WE   = (E_WE0 > E_SD) ? E_WE0 : E_SD;
  localparam int E_WC   = (25000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WR   = (E_WE + 1 > E_WC) ? E_WE + 1 : E_WC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_valid, host_ready, host_we, host_done;
  logic [19:0] host_addr, mem_addr;
  logic [1:0]  host_be, mem_bs_n;
  logic [15:0] host_wdata, host_rdata, mem_dout, mem_din;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dout_en;

  int total = 0;
  int bad   = 0;
  int n_oe, n_we, n_cs, n_drv, n_strb_bad;
  logic [1:0] cur_be;
  logic prev_oe_n = 1'b1;
  logic        pend = 1'b0;
  logic [19:0] paddr;
  logic [15:0] pdata;
  logic [1:0]  pstrb;
  logic [15:0] mdl [logic [19:0]];
  logic [15:0] shd [logic [19:0]];

  always #4 clk = ~clk;

  asram_ctrl #(.CLK_PS(CLK_PS)) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
    .host_done(host_done), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bs_n(mem_bs_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  function automatic logic [15:0] dflt(input logic [19:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] mdl_get(input logic [19:0] a);
    return mdl.exists(a) ? mdl[a] : dflt(a);
  endfunction

  function automatic logic [15:0] shd_get(input logic [19:0] a);
    return shd.exists(a) ? shd[a] : dflt(a);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model and bus monitor, all sampled away from the active edge
  always @(negedge clk) begin
    logic [15:0] w;
    if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n) begin
      w = mdl_get(mem_addr);
      mem_din = {mem_bs_n[1] ? 8'hEE : w[15:8], mem_bs_n[0] ? 8'hEE : w[7:0]};
    end else begin
      mem_din = 16'hEEEE;
    end
    if (rst_n && mem_dout_en && (!mem_oe_n || !prev_oe_n)) begin
      total++; bad++;
      $display("FAIL R6 bus contention actual=oe_n%0b/%0b expected=1/1", mem_oe_n, prev_oe_n);
    end
    if (!mem_we_n && !mem_cs1_n && mem_cs2) begin
      pend  = 1'b1;
      paddr = mem_addr;
      pdata = mem_dout_en ? mem_dout : 16'hBAD0;
      pstrb = mem_bs_n;
    end else if (pend) begin
      w = mdl_get(paddr);
      if (!pstrb[0]) w[7:0]  = pdata[7:0];
      if (!pstrb[1]) w[15:8] = pdata[15:8];
      mdl[paddr] = w;
      pend = 1'b0;
    end
    if (!mem_oe_n)   n_oe++;
    if (!mem_we_n)   n_we++;
    if (!mem_cs1_n)  n_cs++;
    if (mem_dout_en) n_drv++;
    if (!mem_we_n && mem_bs_n != ~cur_be) n_strb_bad++;
    prev_oe_n = mem_oe_n;
  end

  task automatic do_req(input bit we, input logic [19:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    host_valid = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    cur_be = be; n_oe = 0; n_we = 0; n_cs = 0; n_drv = 0; n_strb_bad = 0;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    lat = 1;
    if (be != 2'b00) check(!host_ready, "R8", "ready while busy", host_ready, 0);
    while (!host_done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = host_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd, exp, wd, old;
    logic [19:0] a;
    int lat;
    rst_n = 1'b0; host_valid = 1'b0; host_we = 1'b0; host_addr = '0;
    host_be = '0; host_wdata = '0; cur_be = 2'b00; mem_din = 16'hEEEE;
    repeat (3) @(negedge clk);
    check(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && mem_bs_n == 2'b11 && !mem_dout_en,
          "R1", "pins in reset", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_bs_n, mem_dout_en}, 7'b1011110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && mem_bs_n == 2'b11 && !mem_dout_en,
          "R1", "pins after reset", {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_bs_n, mem_dout_en}, 7'b1011110);
    check(host_ready && !host_done, "R1", "handshake idle", {host_ready, host_done}, 2'b10);

    for (int i = 0; i < 8; i++) begin
      a = (i == 0) ? 20'h00000 : (i == 7) ? 20'hFFFFF : 20'(i * 32'h21A37);
      for (int b = 0; b < 4; b++) begin
        wd = {a[7:0] ^ 8'(b * 37), a[15:8] + 8'(b)};
        do_req(1'b1, a, 2'(b), wd, rd, lat);
        if (b == 0) begin
          check(lat == 1, "R7", "empty write latency", lat, 1);
          check(n_cs == 0, "R7", "empty write selects", n_cs, 0);
        end else begin
          old = shd_get(a);
          if (b[0]) old[7:0]  = wd[7:0];
          if (b[1]) old[15:8] = wd[15:8];
          shd[a] = old;
          check(lat == E_WR + 1, "R4", "write latency", lat, E_WR + 1);
          check(n_we == E_WE, "R4", "we low cycles", n_we, E_WE);
          check(n_oe == 0, "R4", "oe during write", n_oe, 0);
          check(n_cs == E_WR, "R4", "select cycles", n_cs, E_WR);
          check(n_strb_bad == 0, "R4", "strobes during write", n_strb_bad, 0);
          check(n_drv == E_WE, "R6", "driver cycles", n_drv, E_WE);
        end
      end
      for (int b = 0; b < 4; b++) begin
        do_req(1'b0, a, 2'(b), 16'h0000, rd, lat);
        exp = shd_get(a);
        if (!b[0]) exp[7:0]  = 8'h00;
        if (!b[1]) exp[15:8] = 8'h00;
        if (b == 0) begin
          check(lat == 1, "R7", "empty read latency", lat, 1);
          check(n_cs == 0, "R7", "empty read selects", n_cs, 0);
          check(rd == 16'h0000, "R7", "empty read data", rd, 0);
        end else begin
          check(lat == E_RD + 1, "R2", "read latency", lat, E_RD + 1);
          check(n_oe == E_RD, "R2", "oe low cycles", n_oe, E_RD);
          check(n_we == 0, "R2", "we during read", n_we, 0);
          check(rd == exp, (b == 3) ? "R5" : "R3", "read data", rd, exp);
        end
      end
    end
    @(negedge clk);
    check(host_ready && !host_done && mem_cs1_n, "R8", "idle after sweep",
          {host_ready, host_done, mem_cs1_n}, 3'b101);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule